// File: doc/BRIEF.md
# Gated Power-of-Two Clock Prescaler

This block turns a fast master clock into a slower output clock whose period is the master period times a programmable power of two, from 1 up to 256. A 4-bit exponent selects the ratio. Two control pins switch the output on and off: an output-enable pin and a power-down pin. The block works entirely in the master clock domain, and every change to the output lines up with a boundary of the divided period. As a result the output never shows a shortened high phase.

After reset the output stays held low until the master clock has run a fixed start-up count of cycles. A power-down request stops the divider and forces the output low, but only when the pin stays high for longer than two output periods plus a deglitch interval. Shorter pulses are filtered out. When power-down ends, the start-up hold-off runs again. A `live` status output goes high while the gated output is running.

Top module: `clkpre_top`

## Requirements
- R1: With a live output and exponent x from 1 to 8, `clk_out` repeats every 2^x master cycles and is high for exactly the first 2^(x-1) of them. With x = 0, `clk_out` is high during each high phase of `mclk` and low during each low phase.
- R2: An exponent value above 8 on `exp_in` (for example 12) gives the same output as an exponent of 8.
- R3: A new exponent takes effect only at the end of the current output period. The high or low phase in progress finishes at its old width, and the next period uses the new width.
- R4: After `rst` is released with `oe` high, `live` and `clk_out` stay low for at least 512 master cycles. `live` then rises no later than 512 + 2^x + 6 cycles after the release.
- R5: When `oe` goes low, the high phase in progress finishes at full width. After that `clk_out` stays low and `live` is low.
- R6: When `oe` goes high again, `live` rises in the same cycle as a rising edge of `clk_out`, and the first high phase has full width.
- R7: Power-down takes effect only after `pdn` (after its two-stage input synchroniser) has been high for 2·2^x + DEGLITCH_CYCLES master cycles (20 by default). It then forces `live` and `clk_out` low. A shorter pulse on `pdn` has no effect on `live` or `clk_out`.
- R8: Leaving power-down restarts the 512-cycle start-up hold-off before `live` can rise again.
- R9: While `rst` is high, `clk_out` and `live` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_in | input | 4 | Divide exponent x (values above 8 are treated as 8) |
| oe | input | 1 | Output enable, asynchronous, active high |
| pdn | input | 1 | Power-down request, asynchronous, active high |
| clk_out | output | 1 | Gated divided clock |
| live | output | 1 | High while the gated output is running |

## Verification
The hardest case to reach from the ports is a control change that arrives partway through a high phase. To hit it, the stimulus locks onto a rising edge of `clk_out` seen at the falling edge of `mclk`. It then changes `oe` or `exp_in` one sample later and measures the widths of the runs that follow. The power-down filter is tested on both sides of its threshold: a pulse just short of the threshold at the largest ratio, and a long pulse at a small ratio. After release, the bench times how long the re-armed hold-off lasts.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
  localparam int EXP_W = 4;
  typedef logic [EXP_W-1:0] exp_t;

  // Limit a requested exponent to the largest supported value.
  function automatic exp_t clamp_exp(input exp_t req, input exp_t lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/clkpre_sync.sv
module clkpre_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkpre_startup.sv
module clkpre_startup #(
  parameter int HOLD_CYCLES = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  output logic ready
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] cnt;

  // Counts master cycles once reset and power-down are both released.
  always_ff @(posedge clk) begin
    if (rst || halt) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(HOLD_CYCLES - 1)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/clkpre_pdn_filter.sv
module clkpre_pdn_filter
  import clkpre_pkg::*;
#(
  parameter int MAX_EXP  = 8,
  parameter int DEGLITCH = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  exp_t exp_act,
  output logic active
);
  localparam int LIMIT = (2 << MAX_EXP) + DEGLITCH;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thresh;

  // Required persistence: two output periods plus the deglitch interval.
  always_comb thresh = CW'((32'd2 << exp_act) + 32'(DEGLITCH));

  always_ff @(posedge clk) begin
    if (rst || !req) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (!active) begin
      cnt <= cnt + 1'b1;
      if (cnt >= thresh - 1'b1) active <= 1'b1;
    end
  end
endmodule

// File: rtl/clkpre_divider.sv
module clkpre_divider
  import clkpre_pkg::*;
#(
  parameter int MAX_EXP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic want,
  input  exp_t exp_req,
  output logic div_q,
  output logic gate_q,
  output exp_t exp_act,
  output logic wrap
);
  localparam int   CW    = (MAX_EXP < 1) ? 1 : MAX_EXP;
  localparam exp_t MAX_E = exp_t'(MAX_EXP);

  function automatic logic [CW:0] pow2(input exp_t e);
    return (CW+1)'(1) << e;
  endfunction

  logic [CW-1:0] cnt, cnt_nx, last, half_nx;
  exp_t          exp_nx;
  logic          gate_nx, hi_nx;

  always_comb begin
    exp_nx  = clamp_exp(exp_req, MAX_E);
    last    = CW'(pow2(exp_act) - 1'b1);
    wrap    = (cnt == last);
    cnt_nx  = wrap ? '0 : cnt + 1'b1;
    // At a wrap the next period already uses the newly latched exponent.
    half_nx = wrap ? CW'(pow2(exp_nx) >> 1) : CW'(pow2(exp_act) >> 1);
    hi_nx   = (cnt_nx < half_nx);
    gate_nx = wrap ? want : gate_q;
  end

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      cnt     <= '0;
      gate_q  <= 1'b0;
      div_q   <= 1'b0;
      exp_act <= exp_nx;
    end else begin
      cnt    <= cnt_nx;
      gate_q <= gate_nx;
      div_q  <= hi_nx && gate_nx;
      if (wrap) exp_act <= exp_nx;
    end
  end
endmodule

// File: rtl/clkpre_top.sv
module clkpre_top
  import clkpre_pkg::*;
#(
  parameter int MAX_EXP         = 8,
  parameter int HOLD_CYCLES     = 512,
  parameter int DEGLITCH_CYCLES = 20,
  parameter int SYNC_STAGES     = 2
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             oe,
  input  logic             pdn,
  output logic             clk_out,
  output logic             live
);
  logic [1:0] sync_q;
  logic       oe_s, pdn_s;
  logic       pdn_active, ready, want;
  logic       div_q, gate_q, wrap;
  exp_t       exp_act;
  logic       gate_lo;

  clkpre_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk), .rst(rst), .d({pdn, oe}), .q(sync_q)
  );
  assign oe_s  = sync_q[0];
  assign pdn_s = sync_q[1];

  clkpre_pdn_filter #(.MAX_EXP(MAX_EXP), .DEGLITCH(DEGLITCH_CYCLES)) u_pdn (
    .clk(mclk), .rst(rst), .req(pdn_s), .exp_act(exp_act), .active(pdn_active)
  );

  clkpre_startup #(.HOLD_CYCLES(HOLD_CYCLES)) u_start (
    .clk(mclk), .rst(rst), .halt(pdn_active), .ready(ready)
  );

  assign want = oe_s && ready;

  clkpre_divider #(.MAX_EXP(MAX_EXP)) u_div (
    .clk(mclk), .rst(rst), .stop(pdn_active), .want(want), .exp_req(exp_in),
    .div_q(div_q), .gate_q(gate_q), .exp_act(exp_act), .wrap(wrap)
  );

  // Ratio 1: the gate is re-timed on the falling edge so only whole pulses pass.
  always_ff @(negedge mclk) begin
    if (rst) gate_lo <= 1'b0;
    else     gate_lo <= gate_q && (exp_act == '0);
  end

  assign clk_out = div_q | (mclk & gate_lo);
  assign live    = gate_q;
endmodule

// File: rtl/clkpre_checker.sv
module clkpre_checker
  import clkpre_pkg::*;
(
  input logic mclk,
  input logic rst,
  input logic live,
  input logic div_q,
  input exp_t exp_act,
  input logic pdn_active,
  input logic pdn_s,
  input logic ready
);
  a_r4_hold_off: assert property (@(posedge mclk) disable iff (rst)
    !ready |-> !live);

  a_r7_pdn_forces_off: assert property (@(posedge mclk) disable iff (rst)
    pdn_active |=> !live);

  a_r7_pdn_persisted: assert property (@(posedge mclk) disable iff (rst)
    $rose(pdn_active) |-> $past(pdn_s));

  a_r6_starts_on_edge: assert property (@(posedge mclk) disable iff (rst)
    $rose(live) |-> (div_q || exp_act == '0));

  a_r5_low_when_gated: assert property (@(posedge mclk) disable iff (rst)
    !live |-> !div_q);
endmodule

bind clkpre_top clkpre_checker u_chk (
  .mclk(mclk), .rst(rst), .live(live), .div_q(div_q), .exp_act(exp_act),
  .pdn_active(pdn_active), .pdn_s(pdn_s), .ready(ready)
);

// File: tb/clkpre_top_test.sv
module clkpre_top_test;
  logic       mclk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] exp_in = 4'd1;
  logic       oe = 1'b1;
  logic       pdn = 1'b0;
  logic       clk_out, live;

  int checks = 0;
  int errors = 0;

  always #5 mclk = ~mclk;

  clkpre_top uut (
    .mclk(mclk), .rst(rst), .exp_in(exp_in), .oe(oe), .pdn(pdn),
    .clk_out(clk_out), .live(live)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(negedge mclk);
    #1;
  endtask

  task automatic to_rise();
    int g = 0;
    while (clk_out && g < 2000) begin g++; step(); end
    while (!clk_out && g < 4000) begin g++; step(); end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (clk_out == lvl && n < 2000) begin n++; step(); end
  endtask

  task automatic t_reset();
    rst = 1'b1; exp_in = 4'd1; oe = 1'b1; pdn = 1'b0;
    repeat (4) step();
    chk(!clk_out && !live, "R9", "outputs low in reset", int'(clk_out) + int'(live), 0);
    rst = 1'b0;
  endtask

  task automatic t_startup();
    int n = 0;
    int hi = 0;
    while (!live && n < 3000) begin
      step(); n++;
      if (clk_out && !live) hi++;
    end
    chk(n >= 512 && n <= 518, "R4", "cycles until live", n, 513);
    chk(hi == 0, "R4", "output pulses during hold-off", hi, 0);
  endtask

  task automatic t_ratio(input int x);
    int h, l;
    exp_in = 4'(x);
    to_rise(); to_rise();
    run_len(1'b1, h); run_len(1'b0, l);
    chk(h == (1 << (x - 1)), "R1", $sformatf("high width x=%0d", x), h, 1 << (x - 1));
    chk(l == (1 << (x - 1)), "R1", $sformatf("low width x=%0d", x), l, 1 << (x - 1));
  endtask

  task automatic t_ratio_one();
    exp_in = 4'd0;
    repeat (300) step();
    for (int i = 0; i < 6; i++) begin
      @(posedge mclk); #2;
      chk(clk_out == 1'b1, "R1", "x=0 high phase", int'(clk_out), 1);
      @(negedge mclk); #2;
      chk(clk_out == 1'b0, "R1", "x=0 low phase", int'(clk_out), 0);
    end
  endtask

  task automatic t_clamp();
    int h, l;
    exp_in = 4'd12;
    to_rise(); to_rise();
    run_len(1'b1, h); run_len(1'b0, l);
    chk(h == 128, "R2", "clamped high width", h, 128);
    chk(l == 128, "R2", "clamped low width", l, 128);
  endtask

  task automatic t_change();
    int h, l, h2, l2;
    exp_in = 4'd3;
    to_rise(); to_rise();
    step();
    exp_in = 4'd5;
    run_len(1'b1, h); run_len(1'b0, l); run_len(1'b1, h2); run_len(1'b0, l2);
    chk(h == 3, "R3", "rest of old high phase", h, 3);
    chk(l == 4, "R3", "old low phase", l, 4);
    chk(h2 == 16, "R3", "new high phase", h2, 16);
    chk(l2 == 16, "R3", "new low phase", l2, 16);
  endtask

  task automatic t_enable();
    int h, n;
    int hi = 0;
    exp_in = 4'd3;
    to_rise(); to_rise();
    step();
    oe = 1'b0;
    run_len(1'b1, h);
    chk(h == 3, "R5", "high phase finishes after disable", h, 3);
    repeat (40) begin step(); if (clk_out) hi++; end
    chk(hi == 0, "R5", "pulses while disabled", hi, 0);
    chk(!live, "R5", "live after disable", int'(live), 0);
    oe = 1'b1;
    n = 0;
    while (!live && n < 100) begin step(); n++; end
    chk(clk_out == 1'b1, "R6", "output high when live rises", int'(clk_out), 1);
    run_len(1'b1, h);
    chk(h == 4, "R6", "first high phase width", h, 4);
  endtask

  task automatic t_pdn_short(input int x, input int len);
    int bad = 0;
    exp_in = 4'(x);
    to_rise(); to_rise();
    pdn = 1'b1;
    repeat (len) begin step(); if (!live) bad++; end
    pdn = 1'b0;
    repeat (10) begin step(); if (!live) bad++; end
    chk(bad == 0, "R7", $sformatf("short pulse x=%0d cycles with live low", x), bad, 0);
  endtask

  task automatic t_pdn_long();
    int n;
    exp_in = 4'd1;
    to_rise(); to_rise();
    pdn = 1'b1;
    repeat (20) step();
    chk(live == 1'b1, "R7", "live before threshold", int'(live), 1);
    repeat (20) step();
    chk(!live && !clk_out, "R7", "outputs after long pulse", int'(live) + int'(clk_out), 0);
    pdn = 1'b0;
    n = 0;
    while (!live && n < 2000) begin step(); n++; end
    chk(n >= 512 && n <= 530, "R8", "hold-off after power-down", n, 517);
  endtask

  initial begin
    t_reset();
    t_startup();
    for (int x = 1; x <= 8; x++) t_ratio(x);
    t_ratio_one();
    t_clamp();
    t_change();
    t_enable();
    t_pdn_short(1, 15);
    t_pdn_short(8, 500);
    t_pdn_long();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule